// File: doc/BRIEF.md
# SPI Controller Operating-State and Error-Flag Register

This block keeps the operating state of an SPI controller: an enable bit that selects between configuration mode (low) and active mode (high), a master-select bit, and six sticky error flags: mode error, transmit error, receive error, abort, transmit underflow and receive underflow. Software never writes these bits directly. It writes a strobe word in which each state bit has its own set bit and its own clear bit. It reads the live values back through a status word that also shows the shift engine's busy line.

Hardware event inputs raise the flags. Transmit overflow, receive overflow, abort, transmit underflow and receive underflow each pass through a per-source check gate held in a configuration word. A mode fault sets its flag with no gate. The configuration word also carries the frame width and the clock mode for the shift engine. It accepts writes only in configuration mode. A single error interrupt is raised while any error flag is set and the interrupt-enable word allows it.

Top module: `spi_state_reg`

## Requirements
- R1: After reset, enable, master and all six error flags are 0. The configuration word is 0, the interrupt-enable word is 0 and the error interrupt is low.
- R2: A write of 1 to a set bit of the strobe word (address 0) sets the matching state bit. The set bits are: enable at 1, master at 3, receive underflow at 5, mode error at 7, and transmit error, receive error, abort and transmit underflow at 12, 13, 14 and 15. The status word (address 1) shows enable at bit 0, master at 1, mode error at 7, transmit error at 8, receive error at 9, abort at 10, transmit underflow at 11 and receive underflow at 12.
- R3: A write of 1 to a clear bit of the strobe word clears the matching state bit. The clear bits are: enable at 0, master at 2, receive underflow at 4, mode error at 6, and transmit error, receive error, abort and transmit underflow at 8, 9, 10 and 11.
- R4: When one write asserts both the set bit and the clear bit of the same state bit, the bit ends up 0.
- R5: Strobe bits written as 0 leave their state bits unchanged. Writes to the status address change no state.
- R6: A transmit-overflow, receive-overflow, abort, transmit-underflow or receive-underflow event sets its flag only while its check gate is 1. The check gates sit in the configuration word (address 2) at bits 8, 9, 10, 11 and 12, in that order.
- R7: A mode-fault event sets the mode error flag whatever the check gates hold.
- R8: A gated hardware event and a software clear of the same flag in the same cycle leave the flag set.
- R9: One strobe write can set master and clear all six error flags together.
- R10: The configuration word accepts a write only while enable is 0, judged before the write. While enable is 1, a write to it is ignored, and its value drives the mode_cfg_o output.
- R11: err_irq_o is high exactly when bit 2 of the interrupt-enable word (address 3) is 1 and at least one error flag is set.
- R12: Status bit 13 follows busy_i. The strobe address reads as 0.
- R13: enable_o and master_o follow the enable and master state bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| ev_tx_ovf | input | 1 | Transmit overflow event |
| ev_rx_ovf | input | 1 | Receive overflow event |
| ev_abort | input | 1 | Abort event |
| ev_tx_udf | input | 1 | Transmit underflow event |
| ev_rx_udf | input | 1 | Receive underflow event |
| ev_mode_fault | input | 1 | Mode fault event |
| busy_i | input | 1 | Shift engine busy |
| enable_o | output | 1 | Active mode |
| master_o | output | 1 | Master select |
| mode_cfg_o | output | CFG_W | Configuration word (width-1 [4:0], phase 5, polarity 6, bit order 7, check gates 12:8) |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The bench targets four conflicts. The first is a write that sets and clears the same bit; a design that lets set win leaves enable or a flag stuck at 1. The second is an event that lands in the same cycle as a software clear; a design that gives the clear priority loses an error report. The third is a write to the configuration word while active; a design without the lock lets width or check gates change under a running transfer. The fourth is an event whose gate is off; a design without the gate raises spurious flags. Beyond those directed cases, random strobe, event and configuration traffic is compared every cycle against a bit-level model that reads each field position straight from the requirements.

// File: rtl/spi_state_pkg.sv
package spi_state_pkg;

  localparam int NUM_STATE = 8;
  localparam int STRB_W    = 16;
  localparam int CFG_W     = 13;
  localparam int IRQ_W     = 3;

  // state bit order inside the flag bank
  localparam int ST_EN  = 0;
  localparam int ST_MS  = 1;
  localparam int ST_ME  = 2;
  localparam int ST_TE  = 3;
  localparam int ST_RE  = 4;
  localparam int ST_AE  = 5;
  localparam int ST_TUE = 6;
  localparam int ST_RUE = 7;

  localparam int REG_STROBE = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_CFG    = 2;
  localparam int REG_IRQEN  = 3;

  localparam int STS_BUSY_BIT = 13;
  localparam int IRQ_ERR_BIT  = 2;

  function automatic int strobe_set_pos(input int idx);
    case (idx)
      ST_EN:   return 1;
      ST_MS:   return 3;
      ST_ME:   return 7;
      ST_TE:   return 12;
      ST_RE:   return 13;
      ST_AE:   return 14;
      ST_TUE:  return 15;
      default: return 5;
    endcase
  endfunction

  function automatic int strobe_clr_pos(input int idx);
    case (idx)
      ST_EN:   return 0;
      ST_MS:   return 2;
      ST_ME:   return 6;
      ST_TE:   return 8;
      ST_RE:   return 9;
      ST_AE:   return 10;
      ST_TUE:  return 11;
      default: return 4;
    endcase
  endfunction

  function automatic int status_pos(input int idx);
    case (idx)
      ST_EN:   return 0;
      ST_MS:   return 1;
      default: return idx + 5;
    endcase
  endfunction

  // check gate bit in the configuration word for gated sources (TE..RUE)
  function automatic int gate_pos(input int idx);
    return idx + 5;
  endfunction

endpackage

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] q_r;
  logic [N-1:0] ce;
  logic [N-1:0] d;

  // event beats clear, clear beats set
  always_comb begin
    ce = set_i | clr_i | ev_i;
    d  = ev_i | (set_i & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ce[i]) q_r[i] <= d[i];
      end
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/spi_guard_reg.sv
module spi_guard_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic         lock_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;
  logic         ce;

  always_comb ce = we_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (ce) q_r <= d_i;
  end

  assign q_o = q_r;

endmodule

// File: rtl/spi_rd_mux.sv
module spi_rd_mux
  import spi_state_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_STATE-1:0] state_i,
  input  logic                 busy_i,
  input  logic [CFG_W-1:0]     cfg_i,
  input  logic [IRQ_W-1:0]     irqen_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  logic [DATA_W-1:0] sts;

  always_comb begin
    sts = '0;
    for (int i = 0; i < NUM_STATE; i++) sts[status_pos(i)] = state_i[i];
    sts[STS_BUSY_BIT] = busy_i;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr == ADDR_W'(REG_STATUS))     rd_data_o = sts;
    else if (rd_addr == ADDR_W'(REG_CFG))   rd_data_o[CFG_W-1:0] = cfg_i;
    else if (rd_addr == ADDR_W'(REG_IRQEN)) rd_data_o[IRQ_W-1:0] = irqen_i;
  end

endmodule

// File: rtl/spi_state_reg.sv
module spi_state_reg
  import spi_state_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_tx_ovf,
  input  logic              ev_rx_ovf,
  input  logic              ev_abort,
  input  logic              ev_tx_udf,
  input  logic              ev_rx_udf,
  input  logic              ev_mode_fault,
  input  logic              busy_i,
  output logic              enable_o,
  output logic              master_o,
  output logic [CFG_W-1:0]  mode_cfg_o,
  output logic              err_irq_o
);

  localparam int ERR_LO = ST_ME;

  logic [1:0]           rst_sync;
  logic                 rst_sn;
  logic                 strobe_we, cfg_we, irq_we;
  logic [NUM_STATE-1:0] set_v, clr_v, ev_raw, ev_g, state_q;
  logic [CFG_W-1:0]     cfg_q;
  logic [IRQ_W-1:0]     irqen_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  always_comb begin
    strobe_we = wr_en && (wr_addr == ADDR_W'(REG_STROBE));
    cfg_we    = wr_en && (wr_addr == ADDR_W'(REG_CFG));
    irq_we    = wr_en && (wr_addr == ADDR_W'(REG_IRQEN));
  end

  always_comb begin
    for (int i = 0; i < NUM_STATE; i++) begin
      set_v[i] = strobe_we && wr_data[strobe_set_pos(i)];
      clr_v[i] = strobe_we && wr_data[strobe_clr_pos(i)];
    end
  end

  assign ev_raw = {ev_rx_udf, ev_tx_udf, ev_abort, ev_rx_ovf, ev_tx_ovf,
                   ev_mode_fault, 2'b00};

  for (genvar i = 0; i < NUM_STATE; i++) begin : g_ev
    if (i >= ST_TE) begin : g_gated
      assign ev_g[i] = ev_raw[i] & cfg_q[gate_pos(i)];
    end else if (i == ST_ME) begin : g_open
      assign ev_g[i] = ev_raw[i];
    end else begin : g_none
      assign ev_g[i] = 1'b0;
    end
  end

  spi_flag_bank #(.N(NUM_STATE)) u_flags (
    .clk   (clk),
    .rst_n (rst_sn),
    .set_i (set_v),
    .clr_i (clr_v),
    .ev_i  (ev_g),
    .q_o   (state_q)
  );

  spi_guard_reg #(.W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sn),
    .we_i   (cfg_we),
    .lock_i (state_q[ST_EN]),
    .d_i    (wr_data[CFG_W-1:0]),
    .q_o    (cfg_q)
  );

  spi_guard_reg #(.W(IRQ_W)) u_irqen (
    .clk    (clk),
    .rst_n  (rst_sn),
    .we_i   (irq_we),
    .lock_i (1'b0),
    .d_i    (wr_data[IRQ_W-1:0]),
    .q_o    (irqen_q)
  );

  spi_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rd_addr   (rd_addr),
    .state_i   (state_q),
    .busy_i    (busy_i),
    .cfg_i     (cfg_q),
    .irqen_i   (irqen_q),
    .rd_data_o (rd_data)
  );

  assign enable_o   = state_q[ST_EN];
  assign master_o   = state_q[ST_MS];
  assign mode_cfg_o = cfg_q;
  assign err_irq_o  = irqen_q[IRQ_ERR_BIT] && (|state_q[NUM_STATE-1:ERR_LO]);

endmodule

// File: rtl/spi_state_chk.sv
module spi_state_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [7:0]        ev_raw,
  input logic [7:0]        state_q,
  input logic [12:0]       cfg_q,
  input logic [2:0]        irqen_q,
  input logic              err_irq
);

  logic strobe_wr;
  assign strobe_wr = wr_en && (wr_addr == ADDR_W'(0));

  // R4
  both_en_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_wr && wr_data[0] && wr_data[1]) |=> !state_q[0]);

  // R3
  clr_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_wr && wr_data[2]) |=> !state_q[1]);

  // R8
  ev_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_raw[5] && cfg_q[10] && strobe_wr && wr_data[10]) |=> state_q[5]);

  // R7
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_raw[2] |=> state_q[2]);

  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[0] |=> $stable(cfg_q));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irqen_q[2] |-> !err_irq);

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (state_q[7:2] != 6'b0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_wr && ev_raw == 8'b0) |=> $stable(state_q));

endmodule

bind spi_state_reg spi_state_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sn),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .ev_raw  (ev_raw),
  .state_q (state_q),
  .cfg_q   (cfg_q),
  .irqen_q (irqen_q),
  .err_irq (err_irq_o)
);

// File: tb/sim_spi_state_reg.sv
module sim_spi_state_reg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        ev_txo, ev_rxo, ev_ab, ev_txu, ev_rxu, ev_mf;
  logic        busy;
  logic        en_o, ms_o, irq_o;
  logic [12:0] cfg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // model: err order ME,TE,RE,AE,TUE,RUE
  logic        m_en, m_ms;
  logic [5:0]  m_err;
  logic [12:0] m_cfg;
  logic [2:0]  m_irq;

  always #4 clk = ~clk;

  spi_state_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_tx_ovf(ev_txo), .ev_rx_ovf(ev_rxo), .ev_abort(ev_ab),
    .ev_tx_udf(ev_txu), .ev_rx_udf(ev_rxu), .ev_mode_fault(ev_mf),
    .busy_i(busy), .enable_o(en_o), .master_o(ms_o),
    .mode_cfg_o(cfg_o), .err_irq_o(irq_o)
  );

  function automatic logic [15:0] exp_status();
    logic [15:0] s = '0;
    s[0] = m_en;  s[1] = m_ms;
    s[7] = m_err[0]; s[8] = m_err[1]; s[9] = m_err[2];
    s[10] = m_err[3]; s[11] = m_err[4]; s[12] = m_err[5];
    s[13] = busy;
    return s;
  endfunction

  function automatic logic upd(input logic f, input logic ev, input logic c, input logic s);
    return ev | (~c & (s | f));
  endfunction

  // ev order: [0] tx ovf [1] rx ovf [2] abort [3] tx udf [4] rx udf [5] mode fault
  task automatic model(input logic we, input logic [1:0] a, input logic [15:0] d,
                       input logic [5:0] ev);
    logic [15:0] s;
    logic        old_en;
    s = (we && a == 2'd0) ? d : 16'h0;
    old_en = m_en;
    if (s[0]) m_en = 0; else if (s[1]) m_en = 1;
    if (s[2]) m_ms = 0; else if (s[3]) m_ms = 1;
    m_err[0] = upd(m_err[0], ev[5],              s[6],  s[7]);
    m_err[1] = upd(m_err[1], ev[0] & m_cfg[8],   s[8],  s[12]);
    m_err[2] = upd(m_err[2], ev[1] & m_cfg[9],   s[9],  s[13]);
    m_err[3] = upd(m_err[3], ev[2] & m_cfg[10],  s[10], s[14]);
    m_err[4] = upd(m_err[4], ev[3] & m_cfg[11],  s[11], s[15]);
    m_err[5] = upd(m_err[5], ev[4] & m_cfg[12],  s[4],  s[5]);
    if (we && a == 2'd2 && !old_en) m_cfg = d[12:0];
    if (we && a == 2'd3) m_irq = d[2:0];
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [15:0] d,
                      input logic [5:0] ev, input logic bz);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; busy = bz;
    {ev_mf, ev_rxu, ev_txu, ev_ab, ev_rxo, ev_txo} = ev;
    @(posedge clk);
    model(we, a, d, ev);
    #2;
    wr_en = 0; {ev_mf, ev_rxu, ev_txu, ev_ab, ev_rxo, ev_txo} = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    rd_addr = 2'd1; #1;
    chk(tag, {16'h0, rd_data}, {16'h0, exp_status()});
    chk(tag, {29'h0, en_o, ms_o, irq_o}, {29'h0, m_en, m_ms, m_irq[2] & (|m_err)});
  endtask

  task automatic chk_rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
    rd_addr = a; #1;
    chk(tag, {16'h0, rd_data}, {16'h0, exp});
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 1; busy = 0;
    {ev_mf, ev_rxu, ev_txu, ev_ab, ev_rxo, ev_txo} = '0;
    m_en = 0; m_ms = 0; m_err = 0; m_cfg = 0; m_irq = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk_state("R1 reset");
    chk_rd("R1 cfg reset", 2'd2, 16'h0);
    chk_rd("R1 irqen reset", 2'd3, 16'h0);
    // R2 R13 set enable
    step(1, 2'd0, 16'h0002, 6'h0, 0); chk_state("R2 R13 set enable");
    // R10 cfg locked while active
    step(1, 2'd2, 16'h1F07, 6'h0, 0); chk_rd("R10 cfg locked", 2'd2, 16'h0);
    chk("R10 cfg out locked", {19'h0, cfg_o}, 32'h0);
    // R3 clear enable, then cfg write accepted
    step(1, 2'd0, 16'h0001, 6'h0, 0); chk_state("R3 clear enable");
    step(1, 2'd2, 16'h1F07, 6'h0, 0); chk_rd("R10 cfg open", 2'd2, 16'h1F07);
    // R4 both set and clear of enable
    step(1, 2'd0, 16'h0003, 6'h0, 0); chk_state("R4 set+clear enable");
    // R2 set all six errors, R11 irq masked
    step(1, 2'd0, 16'hF0A0, 6'h0, 0); chk_state("R2 set errors");
    chk("R11 masked", {31'h0, irq_o}, 32'h0);
    step(1, 2'd3, 16'h0004, 6'h0, 0); chk("R11 irq on", {31'h0, irq_o}, 32'h1);
    // R5 zero strobe and status writes
    step(1, 2'd0, 16'h0000, 6'h0, 0); chk_state("R5 zero strobe");
    step(1, 2'd1, 16'hFFFF, 6'h0, 0); chk_state("R5 status write");
    // R9 set master and clear all errors in one write
    step(1, 2'd0, 16'h0F58, 6'h0, 0); chk_state("R9 master+clear");
    chk("R9 errors gone", {16'h0, rd_data}, 32'h0002);
    // R6 gated abort event
    step(0, 2'd0, 16'h0, 6'h04, 0); chk_state("R6 gate on");
    step(1, 2'd0, 16'h0400, 6'h0, 0); chk_state("R3 clear abort");
    step(1, 2'd2, 16'h0007, 6'h0, 0);
    step(0, 2'd0, 16'h0, 6'h1F, 0); chk_state("R6 gates off");
    chk("R6 no flag", {16'h0, rd_data}, 32'h0002);
    // R7 mode fault ungated
    step(0, 2'd0, 16'h0, 6'h20, 0); chk_state("R7 mode fault");
    // R8 event and clear same cycle
    step(1, 2'd2, 16'h0400, 6'h0, 0);
    step(1, 2'd0, 16'h0400, 6'h04, 0); chk_state("R8 event beats clear");
    // R12 busy and strobe reads zero
    step(0, 2'd0, 16'h0, 6'h0, 1); chk_state("R12 busy");
    chk_rd("R12 strobe reads zero", 2'd0, 16'h0);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [1:0]  a;
      logic [15:0] d;
      logic [5:0]  ev;
      a  = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      d  = 16'($urandom);
      ev = 6'($urandom) & 6'($urandom) & 6'($urandom);
      step(($urandom % 3) != 0, a, d, ev, 1'($urandom));
      chk_state("R2 R3 R6 R11 random");
      if (i % 16 == 0) begin
        chk_rd("R10 random cfg", 2'd2, {3'h0, m_cfg});
        chk("R10 cfg out", {19'h0, cfg_o}, {19'h0, m_cfg});
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule